// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block controls sixteen general-purpose pins arranged as two banks of eight. Software reaches it over a byte-wide register port made of an address, write data, a write strobe, a read strobe and registered read data. Every pin owns two registers. The output-control register sets direction, open-drain mode, pull enable, pull selection and the output value. The input-control register returns the synchronized pin level and holds the pin's edge-detection code.

Pin inputs are synchronized. An edge of the kind a pin selects sets that pin's pending flag. Software clears a pending flag by writing a one to its bit. One mask register per bank gates the pending flags onto a single interrupt line, and a set mask bit blocks its pin. The pull and drive settings appear only as configuration outputs, for the pad ring to use.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every pin is an input and has detection disabled. Every mask bit is 1 (masked), every pending bit is 0, pin_oe is all zero and irq is 0.
- R2: The output-control register of pin n sits at 0x2B+(n mod 8) for bank 0 (pins 0-7) and at 0x3B+(n mod 8) for bank 1 (pins 8-15). Its fields are: bit 5 direction (1 = output), bit 4 open-drain, bit 3 pull enable, bits 2:1 pull select and bit 0 output value. Bits 7:6 read as 0.
- R3: pin_out[n] equals the output-value bit. pin_oe[n] is 1 exactly when direction is 1 and open-drain with value 1 is not selected.
- R4: The open-drain, pull-enable and pull-select fields of pin n appear on pin_od[n], pin_pull_en[n] and pin_pull_sel[2n+1:2n].
- R5: The input-control register of pin n sits at 0x33+(n mod 8) for bank 0 and at 0x43+(n mod 8) for bank 1. Bit 0 reads the level after a two-flop synchronizer, and this bit ignores writes. Bits 2:1 hold the detection code, and the other bits read as 0.
- R6: The detection codes are 0 = none, 1 = falling edge, 2 = rising edge and 3 = both edges. A matching edge sets the pin's pending bit on the third clock edge after the input changes.
- R7: A detected edge sets the pending bit whether or not the pin is masked. The pending flags read at 0x0B (bank 0) and 0x0C (bank 1), where bit k is pin k of that bank.
- R8: Writing a 1 to a pending bit clears it. Writing a 0 leaves it unchanged.
- R9: When an edge and a clearing write reach the same bit in the same cycle, the bit stays set.
- R10: The mask registers are at 0x19 (bank 0) and 0x1A (bank 1), and a 1 masks the pin. irq is the OR over all pins of (pending AND NOT mask), with no added register stage.
- R11: A read from any address outside the register map returns 0x00.
- R12: rdata takes on the addressed register's value at the clock edge that samples rd_en, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 8 | Registered read data |
| pin_in | input | 16 | Raw pin input levels |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Pin output enables |
| pin_od | output | 16 | Open-drain selection per pin |
| pin_pull_en | output | 16 | Pull resistor enable per pin |
| pin_pull_sel | output | 32 | Pull selection, two bits per pin |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
- Register writes land at the edge that samples wr_en. pin_out, pin_oe and the configuration outputs follow at that edge, so the bench samples them at the next falling clock edge.
- Read data is due one edge after rd_en.
- A pin change made at a falling edge is seen as a pending bit and on irq after the third rising edge. The bench samples irq both after the second rising edge and after the third, to confirm that latency.
- For the same-cycle case, the clearing write is placed so that its strobe is sampled at that third edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   typedef enum logic [1:0] {
      DET_OFF  = 2'd0,
      DET_FALL = 2'd1,
      DET_RISE = 2'd2,
      DET_BOTH = 2'd3
   } det_mode_t;

   // packed so that the MSB is register bit 5 and the LSB is bit 0
   typedef struct packed {
      logic       dir;
      logic       od;
      logic       pull_en;
      logic [1:0] pull_sel;
      logic       val;
   } octl_t;

   localparam int OCTL_W = $bits(octl_t);

endpackage

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
   import gpio_irq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_in,
   input  logic              octl_we,
   input  logic              ictl_we,
   input  logic [OCTL_W-1:0] wbits,
   input  logic              clr,
   output octl_t             octl,
   output det_mode_t         mode,
   output logic              level,
   output logic              pend
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_pin_slice: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sq;
   logic                   prev;
   logic                   hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq   <= '0;
         prev <= 1'b0;
      end else begin
         sq   <= {sq[SYNC_STAGES-2:0], pin_in};
         prev <= sq[SYNC_STAGES-1];
      end
   end

   assign level = sq[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         octl <= '0;
         mode <= DET_OFF;
      end else begin
         if (octl_we) octl <= octl_t'(wbits);
         if (ictl_we) mode <= det_mode_t'(wbits[2:1]);
      end
   end

   always_comb begin
      case (mode)
         DET_FALL: hit = prev & ~level;
         DET_RISE: hit = ~prev & level;
         DET_BOTH: hit = prev ^ level;
         default:  hit = 1'b0;
      endcase
   end

   // an edge in the same cycle as a clear keeps the bit set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= (pend & ~clr) | hit;
   end

   p_pend_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> ($past(mode) != DET_OFF));

   p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && clr) |=> pend);

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !hit) |=> !pend);

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
   parameter int NUM_PINS = 16,
   parameter int BANK_W   = 8
) (
   input  logic [NUM_PINS-1:0] pend,
   input  logic [NUM_PINS-1:0] mask,
   output logic                irq
);

   localparam int NUM_BANKS = NUM_PINS / BANK_W;

   logic [NUM_BANKS-1:0] bank_irq;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign bank_irq[b] = |(pend[b*BANK_W +: BANK_W] & ~mask[b*BANK_W +: BANK_W]);
   end

   assign irq = |bank_irq;

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS    = 16,
   parameter int BANK_W      = 8,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int PEND_BASE   = 'h0B,
   parameter int MASK_BASE   = 'h19,
   parameter int OCTL_BASE   = 'h2B,
   parameter int ICTL_BASE   = 'h33,
   parameter int CTL_STRIDE  = 'h10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     wdata,
   input  logic                  wr_en,
   input  logic                  rd_en,
   output logic [DATA_W-1:0]     rdata,
   input  logic [NUM_PINS-1:0]   pin_in,
   output logic [NUM_PINS-1:0]   pin_out,
   output logic [NUM_PINS-1:0]   pin_oe,
   output logic [NUM_PINS-1:0]   pin_od,
   output logic [NUM_PINS-1:0]   pin_pull_en,
   output logic [2*NUM_PINS-1:0] pin_pull_sel,
   output logic                  irq
);

   localparam int NUM_BANKS = NUM_PINS / BANK_W;

   if (BANK_W != DATA_W) begin : g_bad_bank
      $error("gpio_irq_ctrl: BANK_W must equal DATA_W");
   end
   if (NUM_PINS % BANK_W != 0) begin : g_bad_pins
      $error("gpio_irq_ctrl: NUM_PINS must be a multiple of BANK_W");
   end
   if (DATA_W < OCTL_W) begin : g_bad_data
      $error("gpio_irq_ctrl: DATA_W too narrow for control fields");
   end

   function automatic logic [ADDR_W-1:0] octl_addr(int i);
      return ADDR_W'(OCTL_BASE + (i / BANK_W) * CTL_STRIDE + (i % BANK_W));
   endfunction

   function automatic logic [ADDR_W-1:0] ictl_addr(int i);
      return ADDR_W'(ICTL_BASE + (i / BANK_W) * CTL_STRIDE + (i % BANK_W));
   endfunction

   octl_t                octl_v  [NUM_PINS];
   det_mode_t            mode_v  [NUM_PINS];
   logic [NUM_PINS-1:0]  level_v;
   logic [NUM_PINS-1:0]  pend_v;
   logic [NUM_PINS-1:0]  mask_q;
   logic [NUM_PINS-1:0]  clr_v;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      localparam int B = i / BANK_W;
      localparam int K = i % BANK_W;
      logic octl_we, ictl_we;

      assign octl_we  = wr_en && (addr == octl_addr(i));
      assign ictl_we  = wr_en && (addr == ictl_addr(i));
      assign clr_v[i] = wr_en && (addr == ADDR_W'(PEND_BASE + B)) && wdata[K];

      gpio_pin_slice #(.SYNC_STAGES(SYNC_STAGES)) u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin_in  (pin_in[i]),
         .octl_we (octl_we),
         .ictl_we (ictl_we),
         .wbits   (wdata[OCTL_W-1:0]),
         .clr     (clr_v[i]),
         .octl    (octl_v[i]),
         .mode    (mode_v[i]),
         .level   (level_v[i]),
         .pend    (pend_v[i])
      );

      assign pin_out[i]          = octl_v[i].val;
      assign pin_oe[i]           = octl_v[i].dir & ~(octl_v[i].od & octl_v[i].val);
      assign pin_od[i]           = octl_v[i].od;
      assign pin_pull_en[i]      = octl_v[i].pull_en;
      assign pin_pull_sel[2*i+:2] = octl_v[i].pull_sel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else if (wr_en) begin
         for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr == ADDR_W'(MASK_BASE + b))
               mask_q[b*BANK_W +: BANK_W] <= wdata[BANK_W-1:0];
         end
      end
   end

   logic [DATA_W-1:0] rd_next;
   logic              rd_hit;

   always_comb begin
      rd_next = '0;
      rd_hit  = 1'b0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (addr == octl_addr(i)) begin
            rd_next = DATA_W'(octl_v[i]);
            rd_hit  = 1'b1;
         end
         if (addr == ictl_addr(i)) begin
            rd_next = DATA_W'({mode_v[i], level_v[i]});
            rd_hit  = 1'b1;
         end
      end
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (addr == ADDR_W'(PEND_BASE + b)) begin
            rd_next = DATA_W'(pend_v[b*BANK_W +: BANK_W]);
            rd_hit  = 1'b1;
         end
         if (addr == ADDR_W'(MASK_BASE + b)) begin
            rd_next = DATA_W'(mask_q[b*BANK_W +: BANK_W]);
            rd_hit  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_next;
   end

   gpio_irq_merge #(.NUM_PINS(NUM_PINS), .BANK_W(BANK_W)) u_merge (
      .pend (pend_v),
      .mask (mask_q),
      .irq  (irq)
   );

   p_od_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(pin_oe & pin_od & pin_out)));

   p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_hit) |=> (rdata == '0));

   p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

   p_all_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |-> !irq);

endmodule

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  rdata;
   logic [15:0] pin_in = '0;
   logic [15:0] pin_out, pin_oe, pin_od, pin_pull_en;
   logic [31:0] pin_pull_sel;
   logic        irq;

   int n_vec = 0;
   int n_bad = 0;
   logic done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rd_en(rd_en), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .pin_od(pin_od), .pin_pull_en(pin_pull_en),
      .pin_pull_sel(pin_pull_sel), .irq(irq)
   );

   // [16] read-and-compare (1) or write (0), [15:8] address, [7:0] data
   localparam int NV = 18;
   localparam logic [16:0] VEC [NV] = '{
      {1'b1, 8'h19, 8'hFF},   // R1 mask bank0 reset
      {1'b1, 8'h1A, 8'hFF},   // R1 mask bank1 reset
      {1'b1, 8'h0B, 8'h00},   // R1 pending reset
      {1'b1, 8'h2B, 8'h00},   // R1 control reset
      {1'b0, 8'h2B, 8'h3F},
      {1'b1, 8'h2B, 8'h3F},   // R2
      {1'b0, 8'h2B, 8'hC0},
      {1'b1, 8'h2B, 8'h00},   // R2 bits 7:6 not stored
      {1'b0, 8'h42, 8'h2A},
      {1'b1, 8'h42, 8'h2A},   // R2 bank1 pin15
      {1'b0, 8'h4A, 8'hFF},
      {1'b1, 8'h4A, 8'h06},   // R5 code bits only
      {1'b0, 8'h19, 8'h5A},
      {1'b1, 8'h19, 8'h5A},   // R10
      {1'b1, 8'h00, 8'h00},   // R11
      {1'b1, 8'h4B, 8'h00},   // R11
      {1'b1, 8'h1B, 8'h00},   // R11
      {1'b1, 8'h2A, 8'h00}    // R11
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_bad++;
         n_vec++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      logic [7:0] r2;
      wait_cyc(3);
      check("R1 pin_oe reset", pin_oe, 16'h0);
      check("R1 irq reset", irq, 0);
      rst_n = 1'b1;
      wait_cyc(1);

      for (int v = 0; v < NV; v++) begin
         if (VEC[v][16]) begin
            bus_rd(VEC[v][15:8], r);
            check($sformatf("R2/R5/R10/R11/R1 vec%0d", v), r, VEC[v][7:0]);
         end else begin
            bus_wr(VEC[v][15:8], VEC[v][7:0]);
         end
      end

      // R3 output enable and value
      bus_wr(8'h2B, 8'h21);
      check("R3 push-pull high oe", pin_oe[0], 1);
      check("R3 push-pull high out", pin_out[0], 1);
      bus_wr(8'h2B, 8'h31);
      check("R3 open-drain high releases", pin_oe[0], 0);
      bus_wr(8'h2B, 8'h30);
      check("R3 open-drain low drives", {pin_oe[0], pin_out[0]}, 2'b10);
      bus_wr(8'h2B, 8'h01);
      check("R3 input dir no oe", pin_oe[0], 0);

      // R4 configuration outputs
      bus_wr(8'h3B, 8'h1E);
      check("R4 pull_en pin8", pin_pull_en[8], 1);
      check("R4 pull_sel pin8", pin_pull_sel[17:16], 2'd3);
      check("R4 od pin8", pin_od[8], 1);

      // R5 level readback, write to bit0 ignored
      bus_wr(8'h36, 8'h01);
      bus_rd(8'h36, r);
      check("R5 level low write ignored", r, 8'h00);
      pin_in[3] = 1'b1;
      wait_cyc(4);
      bus_rd(8'h36, r);
      check("R5 level high", r, 8'h01);

      // R6 disabled, falling, rising
      bus_wr(8'h19, 8'hFF);
      bus_wr(8'h1A, 8'hFF);
      pin_in[2] = 1'b1; wait_cyc(4); pin_in[2] = 1'b0; wait_cyc(4);
      bus_rd(8'h0B, r);
      check("R6 disabled no pending", r, 8'h00);
      bus_wr(8'h34, 8'h02);
      pin_in[1] = 1'b1; wait_cyc(4);
      bus_rd(8'h0B, r);
      check("R6 falling ignores rise", r, 8'h00);
      pin_in[1] = 1'b0; wait_cyc(4);
      bus_rd(8'h0B, r);
      check("R6 falling sets", r, 8'h02);
      bus_wr(8'h0B, 8'h00);
      bus_rd(8'h0B, r);
      check("R8 write zero keeps", r, 8'h02);
      bus_wr(8'h0B, 8'h02);
      bus_rd(8'h0B, r);
      check("R8 write one clears", r, 8'h00);

      // R7 masked pending, R10 irq gating and R6 latency
      bus_wr(8'h44, 8'h04);
      pin_in[9] = 1'b1;
      wait_cyc(4);
      bus_rd(8'h0C, r);
      check("R7 pending while masked", r, 8'h02);
      check("R10 masked no irq", irq, 0);
      bus_wr(8'h1A, 8'hFD);
      check("R10 unmask raises irq", irq, 1);
      bus_wr(8'h0C, 8'h02);
      check("R10 cleared drops irq", irq, 0);
      pin_in[9] = 1'b0; wait_cyc(4);
      check("R6 rising ignores fall", irq, 0);
      pin_in[9] = 1'b1;
      wait_cyc(2);
      check("R6 not yet after two edges", irq, 0);
      wait_cyc(1);
      check("R6 set on third edge", irq, 1);
      bus_wr(8'h0C, 8'h02);

      // R9 edge wins over clear in the same cycle (pin 0, both edges)
      bus_wr(8'h33, 8'h06);
      pin_in[0] = 1'b1; wait_cyc(4);
      bus_rd(8'h0B, r);
      check("R6 both edges rise", r, 8'h01);
      pin_in[0] = 1'b0;
      wait_cyc(2);
      bus_wr(8'h0B, 8'h01);
      bus_rd(8'h0B, r);
      check("R9 edge wins", r, 8'h01);
      bus_wr(8'h0B, 8'h01);
      bus_rd(8'h0B, r);
      check("R9 later clear works", r, 8'h00);

      // R12 rdata holds between reads
      bus_rd(8'h19, r);
      wait_cyc(3);
      r2 = rdata;
      check("R12 rdata hold", r2, r);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule